// File: doc/BRIEF.md
# Logic Analyzer Trigger and Capture Controller

This block runs a logic-analyzer style capture of a debug bus. While it is armed, it samples the bus at a programmable rate and sends each sample to an external circular buffer through a one-word write port. The write address walks a fixed window and rolls back to the window base when it passes the window end. The block can take its trigger from one selected bus bit, from a masked comparison of the whole bus against a reference word, or from a software-driven manual control bit. For the first two sources, an edge-polarity input chooses whether a rising or a falling transition fires.

After the trigger is accepted, capture continues for a post-trigger interval and then stops by itself. That interval is a 7-bit count scaled by a power-of-two microsecond unit. A status word reports whether the engine is busy, whether the pointer has wrapped during this capture, and the address of the most recent write. From these, software can put the buffer contents back into time order.

Top module: `la_capture_ctrl`

## Requirements
- R1: A rising `la_enable` while the engine is idle or finished arms it. `busy` reads 1 after that edge, the write pointer returns to `BUF_BASE` and the wrap flag clears. A low `la_enable` returns the engine to idle, and `busy` reads 0 after the next clock edge.
- R2: The sample period is `BASE_DIV << rate_code` clocks for `rate_code` 0 to 6. Code 7 gives `BASE_DIV/2` clocks, which is twice the base rate. The first sample falls one period after arming.
- R3: Each sample asserts `wr_en` for exactly one cycle. `wr_data` carries the bus value at the sampling edge. `wr_addr` starts at `BUF_BASE`, rises by one per sample, and goes back to `BUF_BASE` after `BUF_BASE+BUF_WORDS-1`.
- R4: The `status` bits are laid out as follows. Bit 31 is the wrap flag, set by the write to the last window address. Bits 30:16 hold the address of the most recent write. Bit 0 is `busy`. Bits 15:1 read zero.
- R5: With `trig_src`=0, the trigger signal is `dbg_bus[trig_bit]`. It is evaluated only at sample edges, against the value at the previous sample of the same capture. `edge_fall`=0 fires on a 0-to-1 change and `edge_fall`=1 fires on a 1-to-0 change. A steady level never fires, and the first sample after arming never fires.
- R6: With `trig_src`=1, the masked value (`dbg_bus & cmp_mask`) is tested to give the trigger signal, which then has R5's edge rule applied. `cmp_cond` selects the test. 0 means equal to `cmp_ref & cmp_mask`. 1 means not equal to it. 2 means any masked bit is set. 3 means every masked bit is set.
- R7: With `trig_src`=2, a 0-to-1 change of `manual_trig` fires at the clock edge where it is first seen high, independent of sampling. With any other source, `manual_trig` has no effect.
- R8: `busy` falls exactly `post_count * 2^u * CLK_PER_US + 1` clock edges after the triggering edge. Here u is `post_unit`, and code 7 acts as 6.
- R9: Only the first trigger after arming is accepted. Later edges during the post-trigger interval do not change its length, and `trig_src`=3 never fires.
- R10: Sampling and writes continue through the post-trigger interval. No write occurs after the edge at which `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| la_enable | input | 1 | Arm on rising level, abort when low |
| trig_src | input | 2 | 0 bus bit, 1 masked compare, 2 manual, 3 none |
| trig_bit | input | 5 | Bus bit used as trigger in source 0 |
| edge_fall | input | 1 | 0 rising edge, 1 falling edge |
| cmp_cond | input | 2 | Compare condition for source 1 |
| cmp_mask | input | 32 | Compare mask |
| cmp_ref | input | 32 | Compare reference |
| manual_trig | input | 1 | Manual trigger control bit |
| rate_code | input | 3 | Sample-rate code |
| post_unit | input | 3 | Post-trigger unit exponent (microseconds) |
| post_count | input | 7 | Post-trigger unit count |
| dbg_bus | input | 32 | Debug bus being captured |
| busy | output | 1 | Capture in progress |
| status | output | 32 | Wrap flag, last write address, busy |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | 15 | Buffer word address |
| wr_data | output | 32 | Buffer write data |

## Verification
For each result the bench counts registers from the stimulus edge. A sample taken at edge T appears on `wr_en`/`wr_data`/`wr_addr` and in the status pointer after edge T. A trigger at T with zero post-trigger count drops `busy` after edge T+1, and a post-trigger interval of D microseconds drops it after edge T+D*CLK_PER_US+1. Arming and aborting show on `busy` after the next edge. The bench drives inputs on falling edges. It checks write data and address at the falling edge where it first sees `wr_en`, and checks `busy` one falling edge later. It measures sample spacing and post-trigger length by counting rising edges between those observations.

// File: rtl/la_pkg.sv
package la_pkg;
  typedef enum logic [1:0] {
    SRC_BIT = 2'd0,
    SRC_CMP = 2'd1,
    SRC_MAN = 2'd2,
    SRC_OFF = 2'd3
  } la_src_e;

  typedef enum logic [1:0] {
    CND_EQ  = 2'd0,
    CND_NE  = 2'd1,
    CND_ANY = 2'd2,
    CND_ALL = 2'd3
  } la_cond_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_POST  = 2'd2,
    ST_DONE  = 2'd3
  } la_state_e;

  localparam int unsigned MAX_UNIT = 6;
endpackage

// File: rtl/la_timebase.sv
module la_timebase #(
  parameter int unsigned CLK_PER_US = 5,
  parameter int unsigned BASE_DIV   = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       smp_restart,
  input  logic       us_restart,
  input  logic [2:0] rate_code,
  output logic       smp_stb,
  output logic       us_tick
);
  localparam int unsigned SMP_W = $clog2(BASE_DIV * 128);
  localparam int unsigned US_W  = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

  logic [SMP_W-1:0] smp_cnt, period;
  logic [US_W-1:0]  us_cnt;

  always_comb begin
    if (rate_code == 3'd7) period = SMP_W'(BASE_DIV / 2);
    else                   period = SMP_W'(BASE_DIV) << rate_code;
  end

  assign smp_stb = run && (smp_cnt >= period - SMP_W'(1));
  assign us_tick = run && (us_cnt == US_W'(CLK_PER_US - 1));

  always_ff @(posedge clk) begin
    if (rst || smp_restart)   smp_cnt <= '0;
    else if (run) smp_cnt <= smp_stb ? '0 : smp_cnt + SMP_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || us_restart)    us_cnt <= '0;
    else if (run) us_cnt <= us_tick ? '0 : us_cnt + US_W'(1);
  end

  // R2: the shortest period is two clocks, so strobes never touch
  assert_strobe_spacing_R2: assert property (@(posedge clk) disable iff (rst)
    smp_stb |=> !smp_stb);
endmodule

// File: rtl/la_trigger.sv
module la_trigger
  import la_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned SEL_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              smp_stb,
  input  logic [1:0]        src,
  input  logic [SEL_W-1:0]  bit_sel,
  input  logic              edge_fall,
  input  logic [1:0]        cond,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] refv,
  input  logic [DATA_W-1:0] bus,
  input  logic              manual,
  output logic              fire
);
  logic [DATA_W-1:0] masked;
  logic cmp_hit, sig, prev_sig, prev_ok, man_q, edge_ok;

  assign masked = bus & mask;

  always_comb begin
    case (la_cond_e'(cond))
      CND_EQ:  cmp_hit = (masked == (refv & mask));
      CND_NE:  cmp_hit = (masked != (refv & mask));
      CND_ANY: cmp_hit = |masked;
      default: cmp_hit = (masked == mask);
    endcase
  end

  assign sig     = (la_src_e'(src) == SRC_BIT) ? bus[bit_sel] : cmp_hit;
  assign edge_ok = prev_ok && (edge_fall ? (prev_sig && !sig) : (!prev_sig && sig));

  always_comb begin
    case (la_src_e'(src))
      SRC_BIT, SRC_CMP: fire = smp_stb && edge_ok;
      SRC_MAN:          fire = manual && !man_q;
      default:          fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_sig <= 1'b0;
      prev_ok  <= 1'b0;
      man_q    <= 1'b0;
    end else begin
      man_q <= manual;
      if (clear) prev_ok <= 1'b0;
      else if (smp_stb) begin
        prev_sig <= sig;
        prev_ok  <= 1'b1;
      end
    end
  end

  // R5: the first sample after arming only builds history
  assert_no_fire_without_history_R5: assert property (@(posedge clk) disable iff (rst)
    clear |=> !(fire && la_src_e'(src) != SRC_MAN));
endmodule

// File: rtl/la_wr_seq.sv
module la_wr_seq #(
  parameter int unsigned ADDR_W    = 15,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned BUF_BASE  = 16,
  parameter int unsigned BUF_WORDS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              stb,
  input  logic [DATA_W-1:0] bus,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wrap
);
  localparam logic [ADDR_W-1:0] FIRST = ADDR_W'(BUF_BASE);
  localparam logic [ADDR_W-1:0] LAST  = ADDR_W'(BUF_BASE + BUF_WORDS - 1);

  logic [ADDR_W-1:0] ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr     <= FIRST;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      wrap    <= 1'b0;
    end else begin
      wr_en <= stb;
      if (clear) begin
        ptr  <= FIRST;
        wrap <= 1'b0;
      end else if (stb) begin
        wr_addr <= ptr;
        wr_data <= bus;
        if (ptr == LAST) begin
          ptr  <= FIRST;
          wrap <= 1'b1;
        end else begin
          ptr <= ptr + ADDR_W'(1);
        end
      end
    end
  end

  assert_addr_in_window_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_addr >= FIRST && wr_addr <= LAST));
  assert_wrap_on_last_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(wrap) |-> (wr_en && wr_addr == LAST));
  assert_wrap_cleared_R1: assert property (@(posedge clk) disable iff (rst)
    clear |=> !wrap);
endmodule

// File: rtl/la_capture_ctrl.sv
module la_capture_ctrl
  import la_pkg::*;
#(
  parameter int unsigned CLK_PER_US = 5,
  parameter int unsigned BASE_DIV   = 4,
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned BUF_BASE   = 16,
  parameter int unsigned BUF_WORDS  = 32,
  parameter int unsigned DATA_W     = 32,
  localparam int unsigned SEL_W     = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              la_enable,
  input  logic [1:0]        trig_src,
  input  logic [SEL_W-1:0]  trig_bit,
  input  logic              edge_fall,
  input  logic [1:0]        cmp_cond,
  input  logic [DATA_W-1:0] cmp_mask,
  input  logic [DATA_W-1:0] cmp_ref,
  input  logic              manual_trig,
  input  logic [2:0]        rate_code,
  input  logic [2:0]        post_unit,
  input  logic [6:0]        post_count,
  input  logic [DATA_W-1:0] dbg_bus,
  output logic              busy,
  output logic [31:0]       status,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int unsigned REM_W     = 7 + MAX_UNIT;
  localparam int unsigned PTR_FIELD = 15;

  la_state_e        state;
  logic             en_q, arm_pulse, take, smp_stb, us_tick, trig_fire, wrap;
  logic [REM_W-1:0] rem, rem_load;
  logic [2:0]       eff_unit;

  assign arm_pulse = la_enable && !en_q && (state == ST_IDLE || state == ST_DONE);
  assign take      = (state == ST_ARMED) && la_enable && trig_fire;
  assign busy      = (state == ST_ARMED) || (state == ST_POST);
  assign eff_unit  = (post_unit == 3'd7) ? 3'(MAX_UNIT) : post_unit;
  assign rem_load  = REM_W'(post_count) << eff_unit;
  assign status    = {wrap, PTR_FIELD'(wr_addr), 15'd0, busy};

  la_timebase #(.CLK_PER_US(CLK_PER_US), .BASE_DIV(BASE_DIV)) u_tb (
    .clk(clk), .rst(rst), .run(busy), .smp_restart(arm_pulse),
    .us_restart(arm_pulse || take), .rate_code(rate_code),
    .smp_stb(smp_stb), .us_tick(us_tick));

  la_trigger #(.DATA_W(DATA_W)) u_trig (
    .clk(clk), .rst(rst), .clear(arm_pulse), .smp_stb(smp_stb),
    .src(trig_src), .bit_sel(trig_bit), .edge_fall(edge_fall),
    .cond(cmp_cond), .mask(cmp_mask), .refv(cmp_ref), .bus(dbg_bus),
    .manual(manual_trig), .fire(trig_fire));

  la_wr_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUF_BASE(BUF_BASE),
              .BUF_WORDS(BUF_WORDS)) u_wr (
    .clk(clk), .rst(rst), .clear(arm_pulse), .stb(smp_stb), .bus(dbg_bus),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wrap(wrap));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      en_q  <= 1'b0;
      rem   <= '0;
    end else begin
      en_q <= la_enable;
      case (state)
        ST_ARMED: begin
          if (!la_enable) state <= ST_IDLE;
          else if (trig_fire) begin
            state <= ST_POST;
            rem   <= rem_load;
          end
        end
        ST_POST: begin
          if (!la_enable)      state <= ST_IDLE;
          else if (rem == '0)  state <= ST_DONE;
          else if (us_tick)    rem   <= rem - REM_W'(1);
        end
        default: begin
          if (arm_pulse)       state <= ST_ARMED;
          else if (!la_enable) state <= ST_IDLE;
        end
      endcase
    end
  end

  assert_arm_sets_busy_R1: assert property (@(posedge clk) disable iff (rst)
    arm_pulse |=> busy);
  assert_abort_clears_busy_R1: assert property (@(posedge clk) disable iff (rst)
    !la_enable |=> !busy);
  assert_post_holds_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_POST && rem != '0 && la_enable) |=> busy);
  assert_post_never_reloads_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_POST && $past(state) == ST_POST) |-> rem <= $past(rem));
  assert_write_only_when_busy_R10: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(busy));
endmodule

// File: tb/la_capture_ctrl_test.sv
module la_capture_ctrl_test;
  localparam int CPU = 5;
  localparam int BD  = 4;
  localparam int BB  = 16;
  localparam int BW  = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1, la_enable = 1'b0, edge_fall = 1'b0, manual_trig = 1'b0;
  logic [1:0]  trig_src = 2'd3, cmp_cond = 2'd0;
  logic [4:0]  trig_bit = 5'd0;
  logic [31:0] cmp_mask = '0, cmp_ref = '0, dbg_bus = '0;
  logic [2:0]  rate_code = 3'd0, post_unit = 3'd0;
  logic [6:0]  post_count = 7'd0;
  logic        busy, wr_en;
  logic [31:0] status, wr_data;
  logic [14:0] wr_addr;

  la_capture_ctrl uut (
    .clk(clk), .rst(rst), .la_enable(la_enable), .trig_src(trig_src),
    .trig_bit(trig_bit), .edge_fall(edge_fall), .cmp_cond(cmp_cond),
    .cmp_mask(cmp_mask), .cmp_ref(cmp_ref), .manual_trig(manual_trig),
    .rate_code(rate_code), .post_unit(post_unit), .post_count(post_count),
    .dbg_bus(dbg_bus), .busy(busy), .status(status), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data));

  int n_chk = 0, n_fail = 0, ptr_m = BB;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit sig_f(input logic [31:0] v);
    logic [31:0] m;
    m = v & cmp_mask;
    if (trig_src == 2'd0) return v[trig_bit];
    case (cmp_cond)
      2'd0:    return m == (cmp_ref & cmp_mask);
      2'd1:    return m != (cmp_ref & cmp_mask);
      2'd2:    return m != 0;
      default: return m == cmp_mask;
    endcase
  endfunction

  function automatic int period_f(input int r);
    return (r == 7) ? BD / 2 : BD << r;
  endfunction

  task automatic arm();
    @(negedge clk);
    la_enable = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R1 busy after arm", {31'd0, busy}, 32'd1);
    chk(status[31] == 1'b0, "R1 wrap cleared", {31'd0, status[31]}, 32'd0);
    ptr_m = BB;
  endtask

  task automatic disarm();
    @(negedge clk);
    la_enable = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic feed(input logic [31:0] v, input bit exp_fire, input string req);
    int guard;
    dbg_bus = v;
    guard = 0;
    do begin @(negedge clk); guard++; end while (!wr_en && guard < 2000);
    chk(wr_data == v, "R3 data", wr_data, v);
    chk(int'(wr_addr) == ptr_m, "R3 addr", {17'd0, wr_addr}, ptr_m);
    ptr_m = (ptr_m == BB + BW - 1) ? BB : ptr_m + 1;
    @(negedge clk);
    chk(busy == !exp_fire, req, {31'd0, busy}, {31'd0, !exp_fire});
  endtask

  task automatic rate_test(input logic [2:0] r);
    int n;
    trig_src = 2'd3;
    rate_code = r;
    arm();
    do @(negedge clk); while (!wr_en);
    n = 0;
    do begin @(negedge clk); n++; end while (!wr_en && n < 1000);
    chk(n == period_f(int'(r)), "R2 sample period", n, period_f(int'(r)));
    disarm();
  endtask

  task automatic post_run(input logic [2:0] u, input logic [6:0] c, input int exp_n, input bit retrig);
    int n, writes, late;
    trig_src = 2'd2;
    rate_code = 3'd7;
    post_unit = u;
    post_count = c;
    manual_trig = 1'b0;
    arm();
    repeat (3) @(negedge clk);
    manual_trig = 1'b1;
    @(posedge clk);
    n = 0;
    writes = 0;
    forever begin
      @(negedge clk);
      if (!busy || n > 100000) break;
      if (wr_en) writes++;
      if (retrig && n == 2) manual_trig = 1'b0;
      if (retrig && n == 4) manual_trig = 1'b1;
      @(posedge clk);
      n++;
    end
    chk(n == exp_n, retrig ? "R9 retrigger ignored" : "R8 post length", n, exp_n);
    if (exp_n > 4) chk(writes > 0, "R10 writes during post", writes, 1);
    late = 0;
    repeat (8) begin
      @(negedge clk);
      if (wr_en) late++;
    end
    chk(late == 0, "R10 no writes after stop", late, 0);
    manual_trig = 1'b0;
    disarm();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 reset busy", {31'd0, busy}, 0);
    chk(status == 32'd0, "R4 reset status", status, 0);
    chk(wr_en == 1'b0, "R3 reset wr_en", {31'd0, wr_en}, 0);
    rst = 1'b0;

    // R2 sample spacing
    rate_test(3'd0);
    rate_test(3'd2);
    rate_test(3'd3);
    rate_test(3'd7);

    // R1 abort
    trig_src = 2'd3;
    arm();
    @(negedge clk);
    la_enable = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R1 abort", {31'd0, busy}, 0);
    @(negedge clk);

    // R4 wrap and pointer; R9 source off; R7 manual ignored outside source 2
    rate_code = 3'd7;
    arm();
    for (int i = 0; i < 40; i++) begin
      int a;
      a = ptr_m;
      if (i == 5) manual_trig = 1'b1;
      feed($urandom, 1'b0, "R9 no fire with source off");
      chk(status[31] == (i >= BW - 1), "R4 wrap flag", {31'd0, status[31]}, {31'd0, i >= BW - 1});
      chk(int'(status[30:16]) == a, "R4 status pointer", {17'd0, status[30:16]}, a);
      chk(status[15:0] == 16'd1, "R4 low status bits", {16'd0, status[15:0]}, 1);
    end
    manual_trig = 1'b0;
    disarm();

    // R5 directed bit trigger, rising then falling
    post_count = 7'd0;
    trig_src = 2'd0; trig_bit = 5'd5; edge_fall = 1'b0; rate_code = 3'd1;
    arm();
    feed(32'h20, 1'b0, "R5 first sample no fire");
    manual_trig = 1'b1;
    feed(32'h20, 1'b0, "R7 manual ignored, R5 level");
    feed(32'h00, 1'b0, "R5 wrong edge");
    feed(32'h20, 1'b1, "R5 rising fires");
    manual_trig = 1'b0;
    disarm();
    trig_bit = 5'd31; edge_fall = 1'b1;
    arm();
    feed(32'h0, 1'b0, "R5 first sample");
    feed(32'h8000_0000, 1'b0, "R5 rising ignored in falling mode");
    feed(32'h0, 1'b1, "R5 falling fires");
    disarm();

    // R6 directed compare
    trig_src = 2'd1; cmp_cond = 2'd0; edge_fall = 1'b0;
    cmp_mask = 32'h0000_FF00; cmp_ref = 32'h0000_1200;
    arm();
    feed(32'h0, 1'b0, "R6 first sample");
    feed(32'hFFFF_00FF, 1'b0, "R6 no match");
    feed(32'hABCD_12EF, 1'b1, "R6 match fires");
    disarm();

    // R5/R6 constrained random
    for (int k = 0; k < 8; k++) begin
      bit pv, pr, cur, ef, fired;
      logic [31:0] v;
      trig_src = 2'($urandom % 2);
      edge_fall = 1'($urandom % 2);
      trig_bit = 5'($urandom % 32);
      cmp_cond = 2'($urandom % 4);
      cmp_mask = $urandom & 32'h00FF_0F0F;
      cmp_ref = $urandom;
      rate_code = 3'($urandom % 3);
      arm();
      pv = 0; pr = 0; fired = 0;
      for (int s = 0; s < 10 && !fired; s++) begin
        v = ($urandom % 2) ? $urandom : (($urandom & ~cmp_mask) | (cmp_ref & cmp_mask));
        cur = sig_f(v);
        ef = pv && (edge_fall ? (pr && !cur) : (!pr && cur));
        feed(v, ef, (trig_src == 2'd0) ? "R5 random" : "R6 random");
        pv = 1; pr = cur; fired = ef;
      end
      disarm();
    end

    // R7/R8/R9/R10 manual trigger and post-trigger length
    post_run(3'd0, 7'd0, 1, 1'b0);
    post_run(3'd1, 7'd3, 3 * 2 * CPU + 1, 1'b0);
    post_run(3'd2, 7'd5, 5 * 4 * CPU + 1, 1'b1);
    post_run(3'd7, 7'd1, 64 * CPU + 1, 1'b0);

    summary();
  end
endmodule